// File: doc/BRIEF.md
# Packet Command Phase Sequencer

This block runs the host-side protocol of a storage device's packet command once that command has been written. It collects the command packet from data-port writes and presents it to a command executor that lives outside the block. It then walks the transfer through its phases. The interrupt-reason bits, the data-request flag and the per-burst byte count that the host polls are all driven from the phase register.

The executor answers with a data length and a flag that asks for a data-out phase. The block has no data-out support, so that flag ends the sequence with an error. Read data moves through a buffer outside the block. Here only the access size of each host read is counted. Bursts are limited to `BURST_MAX` bytes, and the count is reloaded for each continuation burst until the whole response has been read. Any other command written to the device aborts the sequence.

Top module: `atapi_pkt_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `drq`, `ireason_cd`, `ireason_io`, `irq`, `pkt_error` and `exec_req` are 0, and `byte_count` is 0.
- R2: A command cycle with `cmd_is_packet`=1 enters the command-out phase one clock later. In that phase `drq`=1, `ireason_cd`=1, `ireason_io`=0, `irq`=0 and `pkt_error`=0.
- R3: In command-out, each write adds 1, 2 or 4 bytes (`host_wr_size` 0, 1, 2; code 3 counts as 4), taken from the lowest byte lane upward. Packet byte i lands at `exec_packet[8i+7:8i]`. One clock after the write that brings the total to 12 or more, `exec_req` pulses for one cycle; bytes past the twelfth are dropped. From the next clock the block waits for the executor with `drq`=0, `ireason_cd`=1 and `ireason_io`=0.
- R4: With `exec_req`, `exec_pkt_len` is 10 when packet byte 0 is 0x25, 0x28 or 0x5A, and 12 for every other opcode.
- R5: A response with nonzero length and no data-out request enters data-in one clock later. In data-in `drq`=1, `ireason_cd`=0, `ireason_io`=1 and `irq`=1, and `byte_count` = min(length, `BURST_MAX`).
- R6: A response of length zero enters the completed phase. There `drq`=0, `ireason_cd`=1, `ireason_io`=1, `irq`=1 and `byte_count`=0.
- R7: A response with `exec_rsp_dataout`=1 sets `pkt_error`=1 and `irq`=1, and returns to idle with `drq`, `ireason_cd` and `ireason_io` all 0.
- R8: A host read in data-in lowers `byte_count` by its access size (same encoding as R3, floored at 0) and adds that size to the received total.
- R9: When a read brings `byte_count` to 0 and the received total is still below the response length, the block stays in data-in. It reloads `byte_count` with min(remainder, `BURST_MAX`) and sets `irq`.
- R10: When a read brings `byte_count` to 0 and the received total has reached the response length, the block moves to completed and sets `irq`.
- R11: A `status_rd` cycle clears `irq` one clock later. If an interrupt event happens in the same cycle, the event wins and `irq` stays 1.
- R12: A command cycle with `cmd_is_packet`=0 aborts any sequence. One clock later `drq`, `ireason_cd`, `ireason_io`, `irq`, `pkt_error` and `byte_count` are all 0.
- R13: Host writes outside command-out and host reads outside data-in have no effect: `byte_count`, the phase outputs and `exec_req` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is written this cycle |
| cmd_is_packet | input | 1 | The command written is the packet command |
| status_rd | input | 1 | The host reads status; clears the interrupt |
| host_wr | input | 1 | Data-port write |
| host_wr_data | input | 32 | Write data, byte 0 in bits 7:0 |
| host_wr_size | input | 2 | Write size code: 0=1, 1=2, 2/3=4 bytes |
| host_rd | input | 1 | Data-port read |
| host_rd_size | input | 2 | Read size code, same encoding |
| exec_req | output | 1 | One-cycle pulse: a packet is ready for the executor |
| exec_packet | output | 96 | Collected packet bytes |
| exec_pkt_len | output | 4 | Effective packet length (10 or 12) |
| exec_rsp_valid | input | 1 | Executor response strobe |
| exec_rsp_len | input | LEN_W (20) | Response data length in bytes |
| exec_rsp_dataout | input | 1 | Executor asks for a data-out phase |
| drq | output | 1 | Data request |
| ireason_cd | output | 1 | Interrupt reason: command/data |
| ireason_io | output | 1 | Interrupt reason: direction to host |
| byte_count | output | $clog2(BURST_MAX+1) (16) | Remaining bytes in the current burst |
| pkt_error | output | 1 | Unsupported data-out was requested |
| irq | output | 1 | Interrupt request |

## Verification
Two things can land in the same clock. A status read can arrive in the cycle where a host read empties the burst, so the interrupt's clear and set collide. The bench drives both in one cycle, at the end of a burst and at the final byte. It expects `irq` to stay 1, and on its own a status read must bring `irq` to 0. A write can also cross the twelfth byte in the same cycle it completes the packet. Random mixes of write sizes provoke this, and the bench checks that the surplus lanes never reach `exec_packet`.

// File: rtl/atapi_pkt_pkg.sv
package atapi_pkt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_CMD_OUT   = 3'd1,
    PH_WAIT_EXEC = 3'd2,
    PH_DATA_IN   = 3'd3,
    PH_DONE      = 3'd4
  } phase_e;

  localparam logic [7:0] OP_RD_CAPACITY = 8'h25;
  localparam logic [7:0] OP_READ10      = 8'h28;
  localparam logic [7:0] OP_MSENSE10    = 8'h5A;

  localparam logic [3:0] LEN_SHORT = 4'd10;
  localparam logic [3:0] LEN_FULL  = 4'd12;

  // Access size code to byte count: 0 -> 1, 1 -> 2, 2 and 3 -> 4.
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic is_short_op(input logic [7:0] op);
    return (op == OP_RD_CAPACITY) || (op == OP_READ10) || (op == OP_MSENSE10);
  endfunction

endpackage

// File: rtl/atapi_pkt_collect.sv
module atapi_pkt_collect
  import atapi_pkt_pkg::*;
#(
  parameter int PKT_BYTES = 12,
  parameter int LANES     = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clear,
  input  logic                   wr_en,
  input  logic [8*LANES-1:0]     wr_data,
  input  logic [2:0]             wr_nbytes,
  output logic [8*PKT_BYTES-1:0] packet,
  output logic [3:0]             pkt_len,
  output logic                   done
);

  localparam int CNT_W = $clog2(PKT_BYTES + LANES + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(PKT_BYTES);

  logic [CNT_W-1:0] fill_q;
  logic [CNT_W-1:0] fill_sum;
  logic             accept;
  logic             complete;
  logic [7:0]       opcode;
  logic [7:0]       slot_q [PKT_BYTES];

  assign accept   = wr_en && (fill_q < FULL);
  assign fill_sum = fill_q + CNT_W'(wr_nbytes);
  assign complete = accept && (fill_sum >= FULL);
  assign opcode   = (fill_q == '0) ? wr_data[7:0] : slot_q[0];

  // Byte slots: lane k of a write lands in slot fill_q + k.
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      for (int i = 0; i < PKT_BYTES; i++) slot_q[i] <= '0;
    end else if (accept) begin
      for (int i = 0; i < PKT_BYTES; i++) begin
        for (int k = 0; k < LANES; k++) begin
          if ((CNT_W'(k) < CNT_W'(wr_nbytes)) && (fill_q + CNT_W'(k) == CNT_W'(i)))
            slot_q[i] <= wr_data[8*k +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      fill_q  <= '0;
      done    <= 1'b0;
      pkt_len <= LEN_FULL;
    end else begin
      done <= complete;
      if (accept) fill_q <= complete ? FULL : fill_sum;
      if (complete) pkt_len <= is_short_op(opcode) ? LEN_SHORT : LEN_FULL;
    end
  end

  for (genvar g = 0; g < PKT_BYTES; g++) begin : g_pack
    assign packet[8*g +: 8] = slot_q[g];
  end

endmodule

// File: rtl/atapi_pkt_burst.sv
module atapi_pkt_burst #(
  parameter int LEN_W     = 20,
  parameter int BURST_MAX = 32768
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             clear,
  input  logic                             load,
  input  logic [LEN_W-1:0]                 load_len,
  input  logic                             rd_en,
  input  logic [2:0]                       rd_nbytes,
  output logic [$clog2(BURST_MAX+1)-1:0]   count,
  output logic                             burst_end,
  output logic                             more
);

  localparam int CNT_W = $clog2(BURST_MAX + 1);
  localparam logic [LEN_W:0]   CAP_L = (LEN_W+1)'(BURST_MAX);
  localparam logic [CNT_W-1:0] CAP_C = CNT_W'(BURST_MAX);

  logic [CNT_W-1:0] count_q;
  logic [LEN_W:0]   recv_q;
  logic [LEN_W:0]   total_q;
  logic [LEN_W:0]   recv_next;
  logic [LEN_W:0]   remain;

  function automatic logic [CNT_W-1:0] cap_burst(input logic [LEN_W:0] v);
    if (v > CAP_L) return CAP_C;
    return v[CNT_W-1:0];
  endfunction

  assign recv_next = recv_q + (LEN_W+1)'(rd_nbytes);
  assign remain    = total_q - recv_next;
  assign burst_end = rd_en && (CNT_W'(rd_nbytes) >= count_q);
  assign more      = recv_next < total_q;
  assign count     = count_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count_q <= '0;
      recv_q  <= '0;
      total_q <= '0;
    end else if (load) begin
      total_q <= {1'b0, load_len};
      recv_q  <= '0;
      count_q <= cap_burst({1'b0, load_len});
    end else if (rd_en) begin
      recv_q <= recv_next;
      if (burst_end) count_q <= more ? cap_burst(remain) : '0;
      else           count_q <= count_q - CNT_W'(rd_nbytes);
    end
  end

endmodule

// File: rtl/atapi_pkt_ctrl.sv
module atapi_pkt_ctrl
  import atapi_pkt_pkg::*;
#(
  parameter int LEN_W     = 20,
  parameter int BURST_MAX = 32768
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cmd_valid,
  input  logic                           cmd_is_packet,
  input  logic                           status_rd,
  input  logic                           host_wr,
  input  logic [31:0]                    host_wr_data,
  input  logic [1:0]                     host_wr_size,
  input  logic                           host_rd,
  input  logic [1:0]                     host_rd_size,
  output logic                           exec_req,
  output logic [95:0]                    exec_packet,
  output logic [3:0]                     exec_pkt_len,
  input  logic                           exec_rsp_valid,
  input  logic [LEN_W-1:0]               exec_rsp_len,
  input  logic                           exec_rsp_dataout,
  output logic                           drq,
  output logic                           ireason_cd,
  output logic                           ireason_io,
  output logic [$clog2(BURST_MAX+1)-1:0] byte_count,
  output logic                           pkt_error,
  output logic                           irq
);

  localparam int PKT_BYTES = 12;
  localparam int LANES     = 4;

  phase_e phase_q, phase_d;
  logic   irq_set, irq_d, err_d;
  logic   coll_wr, coll_done;
  logic   bst_load, bst_rd, bst_end, bst_more;

  assign coll_wr  = !cmd_valid && host_wr && (phase_q == PH_CMD_OUT);
  assign bst_load = !cmd_valid && (phase_q == PH_WAIT_EXEC) && exec_rsp_valid &&
                    !exec_rsp_dataout && (exec_rsp_len != '0);
  assign bst_rd   = !cmd_valid && host_rd && (phase_q == PH_DATA_IN);

  atapi_pkt_collect #(.PKT_BYTES(PKT_BYTES), .LANES(LANES)) collect_i (
    .clk       (clk),
    .rst       (rst),
    .clear     (cmd_valid),
    .wr_en     (coll_wr),
    .wr_data   (host_wr_data),
    .wr_nbytes (size_bytes(host_wr_size)),
    .packet    (exec_packet),
    .pkt_len   (exec_pkt_len),
    .done      (coll_done)
  );

  atapi_pkt_burst #(.LEN_W(LEN_W), .BURST_MAX(BURST_MAX)) burst_i (
    .clk       (clk),
    .rst       (rst),
    .clear     (cmd_valid),
    .load      (bst_load),
    .load_len  (exec_rsp_len),
    .rd_en     (bst_rd),
    .rd_nbytes (size_bytes(host_rd_size)),
    .count     (byte_count),
    .burst_end (bst_end),
    .more      (bst_more)
  );

  assign exec_req = coll_done;

  always_comb begin
    phase_d = phase_q;
    irq_set = 1'b0;
    err_d   = pkt_error;
    if (cmd_valid) begin
      phase_d = cmd_is_packet ? PH_CMD_OUT : PH_IDLE;
      err_d   = 1'b0;
    end else begin
      case (phase_q)
        PH_CMD_OUT: if (coll_done) phase_d = PH_WAIT_EXEC;
        PH_WAIT_EXEC: begin
          if (exec_rsp_valid) begin
            irq_set = 1'b1;
            if (exec_rsp_dataout) begin
              phase_d = PH_IDLE;
              err_d   = 1'b1;
            end else if (exec_rsp_len != '0) begin
              phase_d = PH_DATA_IN;
            end else begin
              phase_d = PH_DONE;
            end
          end
        end
        PH_DATA_IN: begin
          if (bst_end) begin
            irq_set = 1'b1;
            if (!bst_more) phase_d = PH_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (cmd_valid)      irq_d = 1'b0;
    else if (irq_set)   irq_d = 1'b1;
    else if (status_rd) irq_d = 1'b0;
    else                irq_d = irq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      drq        <= 1'b0;
      ireason_cd <= 1'b0;
      ireason_io <= 1'b0;
      irq        <= 1'b0;
      pkt_error  <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      drq        <= (phase_d == PH_CMD_OUT) || (phase_d == PH_DATA_IN);
      ireason_cd <= (phase_d == PH_CMD_OUT) || (phase_d == PH_WAIT_EXEC) ||
                    (phase_d == PH_DONE);
      ireason_io <= (phase_d == PH_DATA_IN) || (phase_d == PH_DONE);
      irq        <= irq_d;
      pkt_error  <= err_d;
    end
  end

endmodule

// File: rtl/atapi_pkt_ctrl_sva.sv
module atapi_pkt_ctrl_sva
  import atapi_pkt_pkg::*;
#(
  parameter int LEN_W     = 20,
  parameter int BURST_MAX = 32768
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           cmd_valid,
  input logic                           cmd_is_packet,
  input logic                           status_rd,
  input logic                           host_rd,
  input logic [1:0]                     host_rd_size,
  input logic                           exec_req,
  input logic [95:0]                    exec_packet,
  input logic [3:0]                     exec_pkt_len,
  input logic                           exec_rsp_valid,
  input logic                           exec_rsp_dataout,
  input logic                           drq,
  input logic                           ireason_cd,
  input logic                           ireason_io,
  input logic [$clog2(BURST_MAX+1)-1:0] byte_count,
  input logic                           pkt_error,
  input logic                           irq
);

  localparam int CNT_W = $clog2(BURST_MAX + 1);

  logic [CNT_W-1:0] rd_n;
  assign rd_n = CNT_W'(size_bytes(host_rd_size));

  // R2: a data request always carries a definite direction
  assert_drq_dir_R2: assert property (@(posedge clk) disable iff (rst)
    drq |-> (ireason_cd != ireason_io));

  // R2: command-out never shows a pending interrupt
  assert_cmdout_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (drq && ireason_cd) |-> !irq);

  assert_exec_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    exec_req |=> !exec_req);

  assert_short_len_R4: assert property (@(posedge clk) disable iff (rst)
    (exec_req && is_short_op(exec_packet[7:0])) |-> (exec_pkt_len == 4'd10));

  assert_full_len_R4: assert property (@(posedge clk) disable iff (rst)
    (exec_req && !is_short_op(exec_packet[7:0])) |-> (exec_pkt_len == 4'd12));

  assert_count_cap_R5: assert property (@(posedge clk) disable iff (rst)
    {1'b0, byte_count} <= (CNT_W+1)'(BURST_MAX));

  assert_dataout_err_R7: assert property (@(posedge clk) disable iff (rst)
    (exec_rsp_valid && exec_rsp_dataout && !cmd_valid && !drq && ireason_cd && !ireason_io)
      |=> (pkt_error && irq && !drq && !ireason_cd && !ireason_io));

  assert_read_dec_R8: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !cmd_valid && drq && !ireason_cd && (byte_count > rd_n))
      |=> (byte_count == $past(byte_count) - $past(rd_n)));

  assert_status_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !exec_rsp_valid && !host_rd) |=> !irq);

  assert_abort_R12: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_is_packet)
      |=> (!drq && !irq && !pkt_error && !ireason_cd && !ireason_io && (byte_count == '0)));

endmodule

bind atapi_pkt_ctrl atapi_pkt_ctrl_sva #(.LEN_W(LEN_W), .BURST_MAX(BURST_MAX)) sva_i (
  .clk              (clk),
  .rst              (rst),
  .cmd_valid        (cmd_valid),
  .cmd_is_packet    (cmd_is_packet),
  .status_rd        (status_rd),
  .host_rd          (host_rd),
  .host_rd_size     (host_rd_size),
  .exec_req         (exec_req),
  .exec_packet      (exec_packet),
  .exec_pkt_len     (exec_pkt_len),
  .exec_rsp_valid   (exec_rsp_valid),
  .exec_rsp_dataout (exec_rsp_dataout),
  .drq              (drq),
  .ireason_cd       (ireason_cd),
  .ireason_io       (ireason_io),
  .byte_count       (byte_count),
  .pkt_error        (pkt_error),
  .irq              (irq)
);

// File: tb/atapi_pkt_ctrl_tb_top.sv
module atapi_pkt_ctrl_tb_top;

  localparam int LEN_W = 20;
  localparam int CAP   = 32768;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cmd_valid = 0, cmd_is_packet = 0, status_rd = 0;
  logic             host_wr = 0, host_rd = 0;
  logic [31:0]      host_wr_data = '0;
  logic [1:0]       host_wr_size = '0, host_rd_size = '0;
  logic             exec_req;
  logic [95:0]      exec_packet;
  logic [3:0]       exec_pkt_len;
  logic             exec_rsp_valid = 0, exec_rsp_dataout = 0;
  logic [LEN_W-1:0] exec_rsp_len = '0;
  logic             drq, ireason_cd, ireason_io, pkt_error, irq;
  logic [15:0]      byte_count;

  always #4 clk = ~clk;

  atapi_pkt_ctrl #(.LEN_W(LEN_W), .BURST_MAX(CAP)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_is_packet(cmd_is_packet),
    .status_rd(status_rd), .host_wr(host_wr), .host_wr_data(host_wr_data),
    .host_wr_size(host_wr_size), .host_rd(host_rd), .host_rd_size(host_rd_size),
    .exec_req(exec_req), .exec_packet(exec_packet), .exec_pkt_len(exec_pkt_len),
    .exec_rsp_valid(exec_rsp_valid), .exec_rsp_len(exec_rsp_len),
    .exec_rsp_dataout(exec_rsp_dataout), .drq(drq), .ireason_cd(ireason_cd),
    .ireason_io(ireason_io), .byte_count(byte_count), .pkt_error(pkt_error), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench model
  bit         m_irq;
  bit         m_din;
  int         m_cnt, m_recv, m_len;
  logic [7:0] cur_pkt [12];

  function automatic int nb(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  function automatic int capv(input int v);
    return (v > CAP) ? CAP : v;
  endfunction

  function automatic int exp_len(input logic [7:0] op);
    return (op == 8'h25 || op == 8'h28 || op == 8'h5A) ? 10 : 12;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_outs(input string req, input int e_drq, input int e_cd, input int e_io,
                          input int e_irq, input int e_cnt, input int e_err);
    chk(req, "drq", drq, e_drq);
    chk(req, "ireason_cd", ireason_cd, e_cd);
    chk(req, "ireason_io", ireason_io, e_io);
    chk(req, "irq", irq, e_irq);
    chk(req, "byte_count", byte_count, e_cnt);
    chk(req, "pkt_error", pkt_error, e_err);
  endtask

  task automatic issue_cmd(input bit pkt);
    cmd_valid = 1; cmd_is_packet = pkt;
    @(negedge clk);
    cmd_valid = 0; cmd_is_packet = 0;
    m_irq = 0; m_cnt = 0; m_din = 0;
    if (pkt) chk_outs("R2", 1, 1, 0, 0, 0, 0);
    else     chk_outs("R12", 0, 0, 0, 0, 0, 0);
  endtask

  // mode 0: random sizes, 1: single bytes, 3: size code 3 only
  task automatic send_packet(input logic [7:0] op, input int mode);
    int fill = 0;
    logic [95:0] expv;
    cur_pkt[0] = op;
    for (int i = 1; i < 12; i++) cur_pkt[i] = 8'($urandom);
    for (int i = 0; i < 12; i++) expv[8*i +: 8] = cur_pkt[i];
    while (fill < 12) begin
      logic [1:0] code;
      code = (mode == 1) ? 2'd0 : (mode == 3) ? 2'd3 : 2'($urandom_range(0, 2));
      for (int k = 0; k < 4; k++)
        host_wr_data[8*k +: 8] = (fill + k < 12) ? cur_pkt[fill + k] : 8'($urandom);
      host_wr_size = code; host_wr = 1;
      @(negedge clk);
      host_wr = 0;
      fill += nb(code);
      if (fill < 12) chk("R3", "exec_req early", exec_req, 0);
    end
    chk("R3", "exec_req", exec_req, 1);
    chk("R3", "packet", (exec_packet == expv), 1);
    chk("R4", "pkt_len", exec_pkt_len, exp_len(op));
    @(negedge clk);
    chk("R3", "exec_req pulse end", exec_req, 0);
    chk_outs("R3", 0, 1, 0, 0, 0, 0);
  endtask

  task automatic respond(input int len, input bit dout);
    exec_rsp_valid = 1; exec_rsp_len = LEN_W'(len); exec_rsp_dataout = dout;
    @(negedge clk);
    exec_rsp_valid = 0; exec_rsp_dataout = 0;
    m_irq = 1;
    if (dout) begin
      m_din = 0; m_cnt = 0;
      chk_outs("R7", 0, 0, 0, 1, 0, 1);
    end else if (len == 0) begin
      m_din = 0; m_cnt = 0;
      chk_outs("R6", 0, 1, 1, 1, 0, 0);
    end else begin
      m_din = 1; m_len = len; m_recv = 0; m_cnt = capv(len);
      chk_outs("R5", 1, 0, 1, 1, m_cnt, 0);
    end
  endtask

  task automatic host_read(input logic [1:0] code, input bit stat);
    int n = nb(code);
    string tag = "R8";
    host_rd = 1; host_rd_size = code; status_rd = stat;
    @(negedge clk);
    host_rd = 0; status_rd = 0;
    if (n >= m_cnt) begin
      m_recv += n;
      m_irq = 1;
      if (m_recv < m_len) begin
        m_cnt = capv(m_len - m_recv); tag = stat ? "R11" : "R9";
      end else begin
        m_cnt = 0; m_din = 0; tag = stat ? "R11" : "R10";
      end
    end else begin
      m_cnt -= n; m_recv += n;
      if (stat) begin m_irq = 0; tag = "R11"; end
    end
    if (m_din) chk_outs(tag, 1, 0, 1, m_irq, m_cnt, 0);
    else       chk_outs(tag, 0, 1, 1, m_irq, 0, 0);
  endtask

  task automatic read_all(input int fixed_code);
    int guard = 0;
    while (m_din && guard < 20000) begin
      logic [1:0] c;
      c = (fixed_code >= 0) ? 2'(fixed_code) : 2'($urandom_range(0, 3));
      host_read(c, ($urandom_range(0, 9) == 0));
      guard++;
    end
  endtask

  task automatic status_read();
    status_rd = 1;
    @(negedge clk);
    status_rd = 0;
    m_irq = 0;
    chk("R11", "irq cleared", irq, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk_outs("R1", 0, 0, 0, 0, 0, 0);
    chk("R1", "exec_req", exec_req, 0);

    // R4 short opcode, R6 zero-length response, R11 plain status read
    issue_cmd(1);
    send_packet(8'h28, 1);
    respond(0, 0);
    status_read();

    // R13: write while idle/completed starts nothing
    host_wr = 1; host_wr_size = 2'd2; host_wr_data = 32'hFFFF_FFFF;
    @(negedge clk); host_wr = 0;
    chk("R13", "exec_req idle write", exec_req, 0);
    @(negedge clk);
    chk("R13", "exec_req idle write late", exec_req, 0);
    chk_outs("R13", 0, 1, 1, 0, 0, 0);

    // data-in with an ignored write in the middle (R13)
    issue_cmd(1);
    host_rd = 1; host_rd_size = 2'd2;
    @(negedge clk); host_rd = 0;
    chk_outs("R13", 1, 1, 0, 0, 0, 0);
    send_packet(8'h12, 0);
    respond(100, 0);
    host_read(2'd1, 0);
    host_wr = 1; host_wr_size = 2'd2;
    @(negedge clk); host_wr = 0;
    chk_outs("R13", 1, 0, 1, 1, m_cnt, 0);
    chk("R13", "exec_req", exec_req, 0);
    read_all(2);

    // R7 data-out, code-3 writes, then R12 clears the error
    issue_cmd(1);
    send_packet(8'h5A, 3);
    respond(64, 1);
    issue_cmd(0);

    // R9 large response: capped burst, reload
    issue_cmd(1);
    send_packet(8'h25, 0);
    respond(40000, 0);
    read_all(2);

    // R11 collision at burst end, R10 floor case
    issue_cmd(1);
    send_packet(8'hBE, 0);
    respond(3, 0);
    status_read();
    host_read(2'd2, 1);
    chk("R10", "completed ireason_io", ireason_io, 1);

    // R12 abort in mid data-in
    issue_cmd(1);
    send_packet(8'h03, 0);
    respond(500, 0);
    host_read(2'd2, 0);
    host_read(2'd0, 0);
    issue_cmd(0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [7:0] op;
      int sel, len;
      sel = $urandom_range(0, 5);
      op = (sel == 0) ? 8'h25 : (sel == 1) ? 8'h28 : (sel == 2) ? 8'h5A : 8'($urandom);
      issue_cmd(1);
      send_packet(op, 0);
      len = ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 1200);
      respond(len, ($urandom_range(0, 9) == 0));
      read_all(-1);
      if ($urandom_range(0, 1) == 1) status_read();
    end

    finish_run();
  end

endmodule